// File: doc/BRIEF.md
# Time Coincidence Strobe Generator

This block watches a running time of day, supplied by a local time counter as hours, minutes, seconds and milliseconds, and raises a single-clock strobe when that time coincides with a programmed target. Software programs the target and two control bits through a small address/data/write-enable register port and can read them back. The enable bit stops all strobes. The mode bit picks between matching the whole time of day and matching only the millisecond field. The millisecond-only mode gives one strobe each second, at a chosen offset within the second.

Register writes first land in a shadow copy. The comparator uses a separate active copy, which is loaded from the shadow when the time counter signals a millisecond boundary (`ms_tick`). A new target or mode therefore starts to apply at a clean boundary. The enable bit does not go through the shadow and acts on the strobe output at once.

Top module: `tcs_strobe_top`

## Requirements
- R1: After a write of 0 to enable bit 0 of the control register (address 0), `strobe_out` stays low until enable is written back to 1.
- R2: In full-match mode (control bit 1 = 0), a strobe is produced only when hours, minutes, seconds and milliseconds all equal the active target.
- R3: In millisecond-only mode (control bit 1 = 1), a strobe is produced when the milliseconds equal the active target, whatever the hours, minutes and seconds are.
- R4: In millisecond-only mode, a time counter sweeping milliseconds 0 to 999 through each second produces exactly one strobe per second.
- R5: A strobe lasts one clock cycle. A match that stays true over several cycles produces only one strobe, on its first cycle.
- R6: Writes to the target fields and to the mode bit change only the shadow copy. The active copy takes the shadow value on a clock edge where `ms_tick` is 1, and is otherwise unchanged. A write alone never produces a strobe.
- R7: Register map: address 0 holds the control register (bit 0 enable, bit 1 mode). Addresses 1, 2, 3 and 4 hold hours [4:0], minutes [5:0], seconds [5:0] and milliseconds [9:0]. `reg_rdata` returns the shadow value zero-extended. Addresses 5 to 7 read 0, and writes to them are ignored.
- R8: After reset every register reads 0 (enable off, full-match mode, target 00:00:00.000) and `strobe_out` is low.
- R9: `strobe_out` is high in the cycle after the first clock edge at which the time inputs match the active target while enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (shadow copy) |
| cur_hour | input | 5 | Current hours, 0-23 |
| cur_min | input | 6 | Current minutes, 0-59 |
| cur_sec | input | 6 | Current seconds, 0-59 |
| cur_ms | input | 10 | Current milliseconds, 0-999 |
| ms_tick | input | 1 | Millisecond boundary from the time counter |
| strobe_out | output | 1 | Coincidence strobe, one cycle wide |

## Verification
The assertions check four rules on every cycle. A strobe is never wider than one cycle. A strobe always follows a cycle in which the comparator reported a match, and in millisecond-only mode that match was on the millisecond field. The active target holds still unless a boundary tick occurred. A write that clears enable silences the output on the next cycle. Other properties need a scenario to show them: exactly one strobe per swept second, a newly written target waiting for the next tick, readback of the map, and agreement with an independent model under random time and write traffic.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int MS_W   = 10;
  localparam int TOD_W  = HOUR_W + MIN_W + SEC_W + MS_W;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_HOUR = 1;
  localparam int unsigned ADR_MIN  = 2;
  localparam int unsigned ADR_SEC  = 3;
  localparam int unsigned ADR_MSEC = 4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } major_t;

  typedef struct packed {
    major_t          major;
    logic [MS_W-1:0] ms;
  } tod_t;

  typedef struct packed {
    logic minor_only;
    tod_t tod;
  } cfg_t;
endpackage

// File: rtl/tcs_rst_sync.sv
`timescale 1ns/1ps
module tcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tcs_regs.sv
`timescale 1ns/1ps
module tcs_regs
  import tcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output cfg_t              shadow,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREG = 5;

  logic [NREG-1:0] hit;
  logic            en_q, en_d;
  cfg_t            sh_q, sh_d;

  // one-hot decode of the implemented addresses
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_dec
      assign hit[g] = we && (addr == ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    en_d = en_q;
    sh_d = sh_q;
    if (hit[ADR_CTRL]) begin
      en_d          = wdata[CTRL_EN_BIT];
      sh_d.minor_only = wdata[CTRL_MODE_BIT];
    end
    if (hit[ADR_HOUR]) sh_d.tod.major.hour = wdata[HOUR_W-1:0];
    if (hit[ADR_MIN])  sh_d.tod.major.min  = wdata[MIN_W-1:0];
    if (hit[ADR_SEC])  sh_d.tod.major.sec  = wdata[SEC_W-1:0];
    if (hit[ADR_MSEC]) sh_d.tod.ms         = wdata[MS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      sh_q <= '0;
    end else if (we) begin
      en_q <= en_d;
      sh_q <= sh_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(ADR_CTRL): begin
        rdata[CTRL_EN_BIT]   = en_q;
        rdata[CTRL_MODE_BIT] = sh_q.minor_only;
      end
      ADDR_W'(ADR_HOUR): rdata = DATA_W'(sh_q.tod.major.hour);
      ADDR_W'(ADR_MIN):  rdata = DATA_W'(sh_q.tod.major.min);
      ADDR_W'(ADR_SEC):  rdata = DATA_W'(sh_q.tod.major.sec);
      ADDR_W'(ADR_MSEC): rdata = DATA_W'(sh_q.tod.ms);
      default:           rdata = '0;
    endcase
  end

  assign en     = en_q;
  assign shadow = sh_q;
endmodule

// File: rtl/tcs_commit.sv
`timescale 1ns/1ps
module tcs_commit
  import tcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  cfg_t shadow,
  output cfg_t active
);
  cfg_t act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= '0;
    else if (ms_tick) act_q <= shadow;
  end

  assign active = act_q;
endmodule

// File: rtl/tcs_match.sv
`timescale 1ns/1ps
module tcs_match
  import tcs_pkg::*;
(
  input  cfg_t active,
  input  tod_t cur,
  output logic match
);
  logic major_eq;
  logic minor_eq;

  always_comb begin
    minor_eq = (cur.ms == active.tod.ms);
    major_eq = (cur.major.hour == active.tod.major.hour) &&
               (cur.major.min  == active.tod.major.min)  &&
               (cur.major.sec  == active.tod.major.sec);
    match    = active.minor_only ? minor_eq : (minor_eq && major_eq);
  end
endmodule

// File: rtl/tcs_pulse.sv
`timescale 1ns/1ps
module tcs_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic match,
  output logic strobe
);
  logic prev_q, prev_d;
  logic str_q, str_d;

  always_comb begin
    prev_d = match;
    str_d  = match && !prev_q && en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      str_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      str_q  <= str_d;
    end
  end

  assign strobe = str_q && en;
endmodule

// File: rtl/tcs_strobe_top.sv
`timescale 1ns/1ps
module tcs_strobe_top
  import tcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [HOUR_W-1:0]   cur_hour,
  input  logic [MIN_W-1:0]    cur_min,
  input  logic [SEC_W-1:0]    cur_sec,
  input  logic [MS_W-1:0]     cur_ms,
  input  logic                ms_tick,
  output logic                strobe_out
);
  logic rst_n_i;
  logic en_q;
  cfg_t shadow_cfg;
  cfg_t act_cfg;
  tod_t cur_tod;
  logic match_now;

  assign cur_tod = {cur_hour, cur_min, cur_sec, cur_ms};

  tcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  tcs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .en(en_q), .shadow(shadow_cfg), .rdata(reg_rdata)
  );

  tcs_commit u_commit (
    .clk(clk), .rst_n(rst_n_i), .ms_tick(ms_tick),
    .shadow(shadow_cfg), .active(act_cfg)
  );

  tcs_match u_match (
    .active(act_cfg), .cur(cur_tod), .match(match_now)
  );

  tcs_pulse u_pulse (
    .clk(clk), .rst_n(rst_n_i), .en(en_q), .match(match_now),
    .strobe(strobe_out)
  );
endmodule

// File: rtl/tcs_strobe_chk.sv
`timescale 1ns/1ps
module tcs_strobe_chk
  import tcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [MS_W-1:0]   cur_ms,
  input logic              ms_tick,
  input logic              strobe_out,
  input cfg_t              act_cfg,
  input logic              match_now
);
  // R5
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |=> !strobe_out);

  // R9
  strobe_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |-> $past(match_now));

  // R3
  minor_only_ms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_out && $past(act_cfg.minor_only)) |-> $past(cur_ms == act_cfg.tod.ms));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(act_cfg));

  // R1
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == ADDR_W'(ADR_CTRL) && !reg_wdata[CTRL_EN_BIT]) |-> !strobe_out);
endmodule

bind tcs_strobe_top tcs_strobe_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cur_ms(cur_ms), .ms_tick(ms_tick),
  .strobe_out(strobe_out), .act_cfg(act_cfg), .match_now(match_now)
);

// File: tb/tb_tcs_strobe_top.sv
`timescale 1ns/1ps
module tb_tcs_strobe_top;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [4:0]    c_h = '0;
  logic [5:0]    c_m = '0;
  logic [5:0]    c_s = '0;
  logic [9:0]    c_ms = '0;
  logic          ms_tick = 1'b0;
  logic          strobe_out;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit         m_en, m_mode_sh, m_mode_act, m_prev, m_sq;
  logic [4:0] sh_h, act_h;
  logic [5:0] sh_m, act_m, sh_s, act_s;
  logic [9:0] sh_ms, act_ms;

  tcs_strobe_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_hour(c_h),
    .cur_min(c_m), .cur_sec(c_s), .cur_ms(c_ms), .ms_tick(ms_tick),
    .strobe_out(strobe_out)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_match();
    bit msq = (c_ms == act_ms);
    if (m_mode_act) return msq;
    return msq && c_h == act_h && c_m == act_m && c_s == act_s;
  endfunction

  function automatic logic [DW-1:0] m_read(int a);
    case (a)
      0: return DW'({m_mode_sh, m_en});
      1: return DW'(sh_h);
      2: return DW'(sh_m);
      3: return DW'(sh_s);
      4: return DW'(sh_ms);
      default: return '0;
    endcase
  endfunction

  function automatic void m_reset();
    m_en = 0; m_mode_sh = 0; m_mode_act = 0; m_prev = 0; m_sq = 0;
    sh_h = 0; sh_m = 0; sh_s = 0; sh_ms = 0;
    act_h = 0; act_m = 0; act_s = 0; act_ms = 0;
  endfunction

  // one clock: model follows the requirements, then output is compared (R9 timing)
  task automatic cycle(string tag);
    bit mt, nsq;
    bit exp;
    @(posedge clk);
    mt = m_match();
    nsq = mt && !m_prev && m_en;
    m_prev = mt;
    m_sq = nsq;
    if (ms_tick) begin
      act_h = sh_h; act_m = sh_m; act_s = sh_s; act_ms = sh_ms;
      m_mode_act = m_mode_sh;
    end
    if (reg_we) begin
      case (int'(reg_addr))
        0: begin m_en = reg_wdata[0]; m_mode_sh = reg_wdata[1]; end
        1: sh_h = reg_wdata[4:0];
        2: sh_m = reg_wdata[5:0];
        3: sh_s = reg_wdata[5:0];
        4: sh_ms = reg_wdata[9:0];
        default: ;
      endcase
    end
    @(negedge clk);
    exp = m_sq && m_en;
    chk(strobe_out == exp, tag, int'(strobe_out), int'(exp));
  endtask

  task automatic wr(int a, int d, string tag);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    cycle(tag);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    reg_addr = AW'(a);
    #1;
    chk(reg_rdata == m_read(a), tag, int'(reg_rdata), int'(m_read(a)));
  endtask

  task automatic set_time(int h, int m, int s, int ms);
    c_h = 5'(h); c_m = 6'(m); c_s = 6'(s); c_ms = 10'(ms);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle("R8");
    // R8: reset state of every register and the output
    for (int a = 0; a < 8; a++) rd(a, "R8");
    chk(strobe_out == 1'b0, "R8", int'(strobe_out), 0);

    // R7: map and readback, unused addresses
    wr(1, 16'hFFF3, "R7");
    wr(2, 45, "R7");
    wr(3, 59, "R7");
    wr(4, 999, "R7");
    wr(6, 16'h1234, "R7");
    wr(0, 2, "R7");
    for (int a = 0; a < 8; a++) rd(a, "R7");

    // R6: new target waits for the boundary tick; write gives no pulse
    wr(0, 1, "R6");
    set_time(1, 2, 3, 400);
    ms_tick = 1'b0;
    wr(1, 1, "R6"); wr(2, 2, "R6"); wr(3, 3, "R6"); wr(4, 400, "R6");
    pulses = 0;
    repeat (4) begin cycle("R6"); pulses += int'(strobe_out); end
    chk(pulses == 0, "R6", pulses, 0);
    ms_tick = 1'b1; cycle("R6"); ms_tick = 1'b0;
    pulses = 0;
    // R5: held match gives exactly one pulse
    repeat (6) begin cycle("R5"); pulses += int'(strobe_out); end
    chk(pulses == 1, "R5", pulses, 1);

    // R2: major mismatch blocks pulse in full mode, rematch pulses again
    c_h = 5'd2;
    pulses = 0;
    repeat (3) begin cycle("R2"); pulses += int'(strobe_out); end
    chk(pulses == 0, "R2", pulses, 0);
    c_h = 5'd1;
    repeat (3) begin cycle("R2"); pulses += int'(strobe_out); end
    chk(pulses == 1, "R2", pulses, 1);

    // R4/R3: millisecond-only sweep, one pulse per second at any major time
    wr(0, 3, "R3"); wr(4, 250, "R3"); wr(1, 17, "R3");
    set_time(9, 30, 0, 0);
    ms_tick = 1'b1; cycle("R3");
    pulses = 0;
    for (int s = 0; s < 3; s++)
      for (int ms = 0; ms < 1000; ms++) begin
        set_time(9, 30, s, ms);
        cycle("R4");
        pulses += int'(strobe_out);
      end
    chk(pulses == 3, "R4", pulses, 3);

    // R1: disabled, sweep gives nothing
    wr(0, 2, "R1");
    pulses = 0;
    for (int ms = 0; ms < 1000; ms++) begin
      set_time(5, 6, 7, ms);
      cycle("R1");
      pulses += int'(strobe_out);
    end
    chk(pulses == 0, "R1", pulses, 0);
    ms_tick = 1'b0;

    // random traffic against the model (R9 timing, all modes)
    wr(0, 1, "R9");
    for (int i = 0; i < 6000; i++) begin
      ms_tick = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 5))
        0, 1: set_time(int'(act_h), int'(act_m), int'(act_s), int'(act_ms));
        2:    c_ms = act_ms;
        3:    ;
        default: set_time($urandom_range(0, 23), $urandom_range(0, 59),
                          $urandom_range(0, 59), $urandom_range(0, 999));
      endcase
      if ($urandom_range(0, 19) == 0) begin
        reg_we = 1'b1;
        reg_addr = AW'($urandom_range(0, 7));
        reg_wdata = (reg_addr == '0) ? DW'($urandom_range(1, 3) | ($urandom_range(0, 7) == 0 ? 0 : 1))
                                     : DW'($urandom);
      end
      cycle("R9");
      reg_we = 1'b0;
    end
    for (int a = 0; a < 8; a++) rd(a, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule